// File: doc/BRIEF.md
# Dual-Prescaler Interval Timer

This block is an 8-bit up-counting interval timer. Two free-running prescalers can drive it. The first prescaler divides the system clock. The second counts edges of a slow crystal clock after that clock has passed through a divide-by-eight stage. A 4-bit mode register chooses where the counter's input pulses come from:

- **Normal mode:** a tap of the system-clock prescaler.
- **Time-base mode:** a tap of the crystal prescaler.

Every wrap of the counter from 0xFF to 0x00 raises a sticky interrupt request flag. Software can clear this flag with a strobe.

In time-base mode, software can also restart the time base with a second strobe. That strobe zeroes the crystal prescaler and the counter together, so the next interval starts from a known phase.

Two power-mode inputs control the prescalers:

- **Stop:** freezes both prescalers.
- **Watch:** freezes only the system-clock prescaler. A time base running from the crystal keeps its time through watch mode.

The crystal clock is not used as a clock. It is sampled through a two-flop synchronizer, so all state lives in the system clock domain. The system clock must be several times faster than the crystal clock.

Top module: `xtal_interval_timer`

## Requirements
- R1: The system-clock prescaler is an 11-bit counter. Reset clears it to zero, and it advances by one on every system clock while it is enabled.
- R2: While `stop_mode` or `watch_mode` is 1, the system-clock prescaler holds its value. While `stop_mode` is 1, the crystal prescaler also holds, and crystal edges are discarded. `watch_mode` alone leaves the crystal prescaler running.
- R3: The crystal prescaler takes one step for every eight rising edges of `xtal_in`. Each high phase and each low phase of `xtal_in` must last at least three system clocks.
- R4: After reset, `count` is 0x00. It increases by one on each selected input pulse and holds its value otherwise.
- R5: A selected pulse that arrives while `count` is 0xFF wraps `count` to 0x00 and sets `irq_flag`.
- R6: When `mode_wdata[3]` is written as 0 (normal mode), `mode_wdata[2:0]` values 0 to 7 divide the system clock by 2, 4, 8, 32, 128, 512, 1024 and 2048. A pulse occurs when the matching prescaler bit rises. After N enabled clocks from reset, `count` equals floor((N + d/2) / d) mod 256, where d is the selected divisor.
- R7: When `mode_wdata[3]` is written as 1 (time-base mode), codes 0 to 5 give one pulse per 1, 2, 4, 8, 16 and 32 crystal prescaler steps. Codes 6 and 7 also give one pulse per 32 steps. After A steps from a clear, `count` equals floor((A + d/2) / d) mod 256.
- R8: In time-base mode, a one-cycle `tb_clr` strobe zeroes the crystal prescaler, including its divide-by-eight stage, and the counter. In normal mode, `tb_clr` has no effect.
- R9: `irq_flag` stays at 1 until an `irq_clr` strobe. If an overflow and `irq_clr` occur in the same cycle, the flag ends at 1.
- R10: The mode register loads `mode_wdata` when `mode_we` is 1. Its reset value is 0, which selects normal mode with divide-by-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_in | input | 1 | Slow crystal clock, sampled as data |
| stop_mode | input | 1 | Stop mode: freezes both prescalers |
| watch_mode | input | 1 | Watch mode: freezes the system-clock prescaler only |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 4 | Mode value: bit 3 selects time-base mode, bits 2:0 select the tap |
| irq_clr | input | 1 | Clear strobe for the interrupt request flag |
| tb_clr | input | 1 | Time-base restart strobe (effective in time-base mode only) |
| count | output | 8 | Timer counter value |
| irq_flag | output | 1 | Sticky interrupt request flag |

## Verification
The hardest situation to bring about is an overflow and a flag-clear strobe in the very same cycle. This requires landing exactly on the clock edge where the divided tap fires while the counter sits at 0xFF. The stimulus reaches it by freezing the prescaler with `stop_mode`, counting precisely how many enabled clocks have elapsed since reset, and releasing the freeze for one clock with `irq_clr` raised. A second hard case is showing that `tb_clr` clears the hidden divide-by-eight stage. The bench leaves five crystal edges pending, clears, and then supplies three more edges. The counter must stay put, because it would step if the pending edges had survived the clear.

// File: rtl/itmr_pkg.sv
// Package: shared sizes, the mode register layout and the normal-mode tap map
// for the dual-prescaler interval timer.
// Assumes: the system prescaler is at least 11 bits wide, so every tap index exists.
package itmr_pkg;

    localparam int SYS_PSC_W = 11;   // system-clock prescaler width
    localparam int XT_PRE_W  = 3;    // crystal divide-by-eight stage
    localparam int XT_PSC_W  = 5;    // crystal prescaler width
    localparam int CNT_W     = 8;    // timer counter width
    localparam int CODE_W    = 3;    // tap selection code width
    localparam int NCODE     = 2 ** CODE_W;

    // Mode register: top bit picks time-base mode, low bits pick the tap
    typedef struct packed {
        logic              tbase;
        logic [CODE_W-1:0] code;
    } mode_t;

    // Normal-mode code to system-prescaler bit index (divide = 2^(bit+1))
    function automatic int sys_tap_bit(input int code);
        case (code)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 4;
            4:       return 6;
            5:       return 8;
            6:       return 9;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/itmr_sys_psc.sv
// System-clock prescaler: a free-running up-counter that advances while run is high.
// For each normal-mode tap it emits a one-cycle pulse on the clock edge
// where that prescaler bit goes from 0 to 1.
// Assumes: W is large enough for the highest tap given by itmr_pkg::sys_tap_bit.
module itmr_sys_psc
    import itmr_pkg::*;
#(
    parameter int W = SYS_PSC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [NCODE-1:0] tap_tick
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    // Advance the prescaler on every enabled system clock
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + ONE;
    end

    // One rising-edge pulse per selectable tap
    for (genvar t = 0; t < NCODE; t++) begin : g_tap
        localparam int B = sys_tap_bit(t);
        if (B == 0) begin : g_lsb
            assign tap_tick[t] = run & ~cnt[0];
        end else begin : g_upper
            assign tap_tick[t] = run & ~cnt[B] & (&cnt[B-1:0]);
        end
    end

    AST_SPSC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt == $past(cnt) + ONE); // R1
    AST_SPSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt)); // R2

endmodule

// File: rtl/itmr_xtal_psc.sv
// Crystal prescaler: synchronizes the slow crystal clock with two flops and
// detects its rising edges. A divide-by-eight stage turns every eighth edge
// into one prescaler step. Emits the step pulse and a rising-edge pulse
// for each prescaler bit.
// Assumes: each crystal phase lasts at least three system clocks. clr overrides
// counting and zeroes both stages.
module itmr_xtal_psc
    import itmr_pkg::*;
#(
    parameter int PRE_W = XT_PRE_W,
    parameter int W     = XT_PSC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xtal_in,
    input  logic         run,
    input  logic         clr,
    output logic         adv,
    output logic [W-1:0] tick
);

    localparam logic [PRE_W-1:0] PONE = PRE_W'(1);
    localparam logic [W-1:0]     ONE  = W'(1);

    logic [1:0]       sync;
    logic             seen;
    logic [PRE_W-1:0] pre;
    logic [W-1:0]     psc;
    logic             step;

    // Bring the crystal clock into the system domain and remember its last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= 2'b00;
            seen <= 1'b0;
        end else begin
            sync <= {sync[0], xtal_in};
            seen <= sync[1];
        end
    end

    assign step = run & sync[1] & ~seen;
    assign adv  = step & (&pre);

    // Divide-by-eight stage counts synchronized rising edges
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre <= '0;
        else if (step)     pre <= pre + PONE;
    end

    // Prescaler steps once per completed divide-by-eight cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) psc <= '0;
        else if (adv)      psc <= psc + ONE;
    end

    // Rising-edge pulse of each prescaler bit
    for (genvar k = 0; k < W; k++) begin : g_tick
        if (k == 0) begin : g_lsb
            assign tick[k] = adv & ~psc[0];
        end else begin : g_upper
            assign tick[k] = adv & ~psc[k] & (&psc[k-1:0]);
        end
    end

    AST_XT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre == '0 && psc == '0)); // R8
    AST_XT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(pre) && $stable(psc))); // R2
    AST_XT_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> pre == $past(pre) + PONE); // R3

endmodule

// File: rtl/itmr_tap_sel.sv
// Tap selector: picks the counter's input pulse from the system taps in normal
// mode, or from the crystal prescaler in time-base mode.
// Assumes: in time-base mode, code 0 is the raw prescaler step and codes above W
// saturate at the top prescaler bit.
module itmr_tap_sel
    import itmr_pkg::*;
#(
    parameter int XW = XT_PSC_W
) (
    input  mode_t            mode,
    input  logic [NCODE-1:0] sys_tick,
    input  logic             xt_adv,
    input  logic [XW-1:0]    xt_tick,
    output logic             pulse
);

    logic xt_pick;

    // Crystal-side pick: step pulse for code 0, saturating bit tap otherwise
    always_comb begin
        xt_pick = xt_adv;
        for (int c = 1; c < NCODE; c++) begin
            if (mode.code == CODE_W'(c)) xt_pick = xt_tick[((c > XW) ? XW : c) - 1];
        end
    end

    // Final source choice by the time-base bit
    always_comb begin
        pulse = mode.tbase ? xt_pick : sys_tick[mode.code];
    end

endmodule

// File: rtl/itmr_count.sv
// Timer counter: up-counts on each input pulse, wraps from all-ones to zero,
// and sets a sticky request flag on every wrap.
// Assumes: clr (time-base restart) beats a coincident pulse. An overflow beats
// a coincident flag clear.
module itmr_count
    import itmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         irq_clr,
    output logic [W-1:0] cnt,
    output logic         irq
);

    localparam logic [W-1:0] ONE = W'(1);

    logic ovf;

    assign ovf = tick & ~clr & (&cnt);

    // Counter: restart, step or hold
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= cnt + ONE;
    end

    // Sticky request flag, overflow has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (ovf)     irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> cnt == $past(cnt) + ONE); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt)); // R4
    AST_WRAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt == '1) |=> (cnt == '0 && irq)); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R9
    AST_OVF_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt == '1 && irq_clr) |=> irq); // R9

endmodule

// File: rtl/xtal_interval_timer.sv
// Top: the dual-prescaler interval timer. Holds the mode register, gates the
// prescalers by power mode, routes the selected tap to the counter and applies
// the time-base restart only in time-base mode.
// Assumes: all inputs are synchronous to clk, except xtal_in, which is synchronized inside.
module xtal_interval_timer
    import itmr_pkg::*;
#(
    parameter int SYS_W = SYS_PSC_W,
    parameter int PRE_W = XT_PRE_W,
    parameter int XT_W  = XT_PSC_W,
    parameter int CW    = CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xtal_in,
    input  logic           stop_mode,
    input  logic           watch_mode,
    input  logic           mode_we,
    input  logic [CODE_W:0] mode_wdata,
    input  logic           irq_clr,
    input  logic           tb_clr,
    output logic [CW-1:0]  count,
    output logic           irq_flag
);

    mode_t            mode_q;
    logic             sys_run;
    logic             xt_run;
    logic             tb_clr_eff;
    logic [NCODE-1:0] sys_tick;
    logic             xt_adv;
    logic [XT_W-1:0]  xt_tick;
    logic             tick_sel;

    // Mode register, loaded by the write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_t'(mode_wdata);
    end

    assign sys_run    = ~stop_mode & ~watch_mode;
    assign xt_run     = ~stop_mode;
    assign tb_clr_eff = tb_clr & mode_q.tbase;

    itmr_sys_psc #(.W(SYS_W)) u_sys_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sys_run),
        .tap_tick (sys_tick)
    );

    itmr_xtal_psc #(.PRE_W(PRE_W), .W(XT_W)) u_xt_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .xtal_in (xtal_in),
        .run     (xt_run),
        .clr     (tb_clr_eff),
        .adv     (xt_adv),
        .tick    (xt_tick)
    );

    itmr_tap_sel #(.XW(XT_W)) u_sel (
        .mode     (mode_q),
        .sys_tick (sys_tick),
        .xt_adv   (xt_adv),
        .xt_tick  (xt_tick),
        .pulse    (tick_sel)
    );

    itmr_count #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_sel),
        .clr     (tb_clr_eff),
        .irq_clr (irq_clr),
        .cnt     (count),
        .irq     (irq_flag)
    );

    AST_TBASE_FROM_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.tbase && tick_sel) |-> xt_adv); // R7
    AST_NORMAL_FROM_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.tbase && tick_sel) |-> sys_run); // R6
    AST_TBCLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_clr && !mode_q.tbase && !tick_sel) |=> $stable(count)); // R8
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> mode_q == $past(mode_wdata)); // R10

endmodule

// File: tb/sim_xtal_interval_timer.sv
`timescale 1ns/1ps
module sim_xtal_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_in = 1'b0;
    logic       stop_mode = 1'b1;
    logic       watch_mode = 1'b0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wdata = 4'h0;
    logic       irq_clr = 1'b0;
    logic       tb_clr = 1'b0;
    logic [7:0] count;
    logic       irq_flag;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] cnt;
        logic       flg;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    xtal_interval_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .xtal_in    (xtal_in),
        .stop_mode  (stop_mode),
        .watch_mode (watch_mode),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .irq_clr    (irq_clr),
        .tb_clr     (tb_clr),
        .count      (count),
        .irq_flag   (irq_flag)
    );

    // Normal-mode divisors per code, from R6
    function automatic int norm_div(input int code);
        case (code)
            0: return 2;    1: return 4;    2: return 8;    3: return 32;
            4: return 128;  5: return 512;  6: return 1024; default: return 2048;
        endcase
    endfunction

    // Time-base divisors per code, from R7
    function automatic int tb_div(input int code);
        case (code)
            0: return 1;  1: return 2;  2: return 4;  3: return 8;
            4: return 16; default: return 32;
        endcase
    endfunction

    function automatic int pulses(input int n, input int d);
        return (d == 1) ? n : (n + d / 2) / d;
    endfunction

    // Driver side of the scoreboard: queue one expected observation
    task automatic chk(input string req, input int c, input bit f);
        exp_t e;
        e.req = req;
        e.cnt = c[7:0];
        e.flg = f;
        exp_q.push_back(e);
    endtask

    // Monitor: pops expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                vectors++;
                if (count !== e.cnt || irq_flag !== e.flg) begin
                    miscompares++;
                    $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                             e.req, count, irq_flag, e.cnt, e.flg);
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; stop_mode = 1'b1; watch_mode = 1'b0; mode_we = 1'b0;
        mode_wdata = 4'h0; irq_clr = 1'b0; tb_clr = 1'b0; xtal_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        stop_mode = 1'b0;
        repeat (n) @(negedge clk);
        stop_mode = 1'b1;
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode_we = 1'b1;
        mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic pulse_tbclr();
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic xt_edges(input int e);
        for (int i = 0; i < e; i++) begin
            xtal_in = 1'b1;
            repeat (3) @(negedge clk);
            xtal_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int ns[8];
        int total;
        int steps;
        ns = '{7, 13, 100, 1000, 700, 3000, 3000, 5000};

        // R4 R10: reset state
        do_reset();
        chk("R4 reset count zero", 0, 1'b0);
        @(negedge clk);

        // R6: every normal-mode divisor, each from a fresh reset
        for (int c = 0; c < 8; c++) begin
            do_reset();
            set_mode(4'(c));
            run(ns[c]);
            chk($sformatf("R6 normal code %0d after %0d clocks", c, ns[c]),
                pulses(ns[c], norm_div(c)) % 256, 1'b0);
            @(negedge clk);
        end

        // R10: reset mode is normal divide-by-2, no write needed
        do_reset();
        run(7);
        total = 7;
        chk("R10 default mode divides by 2", pulses(total, 2), 1'b0);
        run(503);
        total += 503;
        chk("R4 count reaches 0xFF", pulses(total, 2) % 256, 1'b0);
        run(1);
        total += 1;
        chk("R5 wrap to zero sets flag", pulses(total, 2) % 256, 1'b1);
        @(negedge clk);
        chk("R9 flag sticky while idle", 0, 1'b1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R9 clear strobe drops flag", 0, 1'b0);
        run(511);
        total += 511;
        chk("R5 at 0xFF before second wrap", pulses(total, 2) % 256, 1'b0);
        irq_clr = 1'b1;
        run(1);
        irq_clr = 1'b0;
        total += 1;
        chk("R9 overflow beats same-cycle clear", pulses(total, 2) % 256, 1'b1);
        stop_mode = 1'b0;
        watch_mode = 1'b1;
        repeat (100) @(negedge clk);
        chk("R2 watch freezes system prescaler", 0, 1'b1);
        watch_mode = 1'b0;
        stop_mode = 1'b1;
        run(10);
        total += 10;
        chk("R1 prescaler resumes", pulses(total, 2) % 256, 1'b1);
        pulse_tbclr();
        chk("R8 restart ignored in normal mode", pulses(total, 2) % 256, 1'b1);
        run(2);
        total += 2;
        chk("R1 prescaler unaffected by restart", pulses(total, 2) % 256, 1'b1);
        @(negedge clk);

        // R7 R3 R8: time-base mode with watch held on
        do_reset();
        set_mode(4'b1000);
        stop_mode = 1'b0;
        watch_mode = 1'b1;
        xt_edges(80);
        chk("R7 time-base code 0 under watch", 10, 1'b0);
        xt_edges(5);
        chk("R3 partial group of eight not counted", 10, 1'b0);
        pulse_tbclr();
        chk("R8 restart zeroes counter", 0, 1'b0);
        xt_edges(3);
        chk("R8 restart zeroes divide-by-eight stage", 0, 1'b0);
        xt_edges(5);
        chk("R3 eighth edge steps prescaler", 1, 1'b0);

        set_mode(4'b1010);
        pulse_tbclr();
        steps = 9;
        xt_edges(8 * steps);
        chk("R7 time-base code 2", pulses(steps, tb_div(2)), 1'b0);

        set_mode(4'b1111);
        pulse_tbclr();
        steps = 48;
        xt_edges(8 * steps);
        chk("R7 time-base code 7 saturates at 32", pulses(steps, tb_div(7)), 1'b0);

        stop_mode = 1'b1;
        xt_edges(16);
        chk("R2 stop freezes crystal prescaler", pulses(steps, tb_div(7)), 1'b0);
        stop_mode = 1'b0;

        set_mode(4'b1000);
        pulse_tbclr();
        xt_edges(8 * 256);
        chk("R5 time-base wrap sets flag", 0, 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule